// File: doc/BRIEF.md
# Timeout event capture FIFO

This block keeps a log of completion-timeout events for outstanding non-posted requests. Each event is a record with the requesting function identity (virtual function number, physical function number, a flag saying whether the virtual function was active), the number of bytes still outstanding, the request tag, the traffic class and the two ordering attributes. Records are pushed on the core clock. Software reads them back one at a time through a byte-wide memory-mapped slave that runs on its own clock.

The oldest record held is shown as six read-only byte registers, next to a status byte and a write-only control byte. Software reads the bytes it needs. It then writes a 1 to the control bit, which discards that record and brings the next one into view. A level alert in the core domain stays high while any record is waiting. When the store is full, newly arriving records are lost without notice.

The slave is a small state machine with three states. CS_IDLE accepts requests and keeps waitrequest low. CS_RESP presents the read byte with the valid strobe for one cycle. CS_POP holds waitrequest for one cycle after a pop so that the new head record can settle. The transitions are:
- IDLE→RESP on an accepted read.
- IDLE→POP on an accepted pop write.
- IDLE→IDLE on any other write, or when there is no request.
- RESP→IDLE and POP→IDLE unconditionally.

Records cross between the clocks through a dual-clock FIFO with Gray-coded pointers. The depth is a parameter; it must be a power of two and at least 4.

Top module: `cto_event_fifo`

## Requirements
- R1: `alert` goes high no later than two core-clock edges after a record is accepted. It stays high while any record is held, and falls a few core cycles after the last record is popped.
- R2: Offset 0 reads as the status byte: bit 0 = empty, bit 1 = full (slave-side view), bits [7:2] = 0. After reset it reads 8'h01.
- R3: Writing a byte with bit 0 = 1 to offset 1 removes the head record. Writing a byte with bit 0 = 0 to offset 1 leaves the head record in place.
- R4: The head record appears at these offsets:
  - 2 = vf[7:0]
  - 3 = {vf_active, 0, pf[2:0], vf[10:8]}
  - 4 = len[7:0]
  - 5 = {0000, len[11:8]}
  - 6 = tag[7:0]
  - 7 = {tc[2:0], relaxed, no_snoop, 0, tag[9:8]}
- R5: While the FIFO is full, pushed records are discarded. Exactly DEPTH records are kept, and the status reads 8'h02 until the first pop.
- R6: A read accepted while `csr_waitreq` is low returns its byte with `csr_rvalid` high in the next cycle. `csr_rvalid` is never high without such a read. `csr_waitreq` is high in CS_RESP and CS_POP.
- R7: A read of the control offset 1 returns 8'h00.
- R8: Writes to offsets 0 and 2 to 7 change nothing.
- R9: While the FIFO is empty, offsets 2 to 7 read 8'h00, and a pop request is ignored.
- R10: Only `csr_addr[2:0]` selects a register. The upper address bits do not affect decoding.
- R11: Records are read out in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core clock for record capture |
| core_rst_n | input | 1 | Active-low async reset, core domain |
| evt_push | input | 1 | Offer a timeout record this cycle |
| evt_vf | input | 11 | Virtual function number |
| evt_pf | input | 3 | Physical function number |
| evt_vf_active | input | 1 | Virtual function active flag |
| evt_len | input | 12 | Bytes still outstanding |
| evt_tag | input | 10 | Request tag |
| evt_tc | input | 3 | Traffic class |
| evt_ro | input | 1 | Relaxed-ordering attribute |
| evt_ns | input | 1 | No-snoop attribute |
| alert | output | 1 | High while records are pending |
| csr_clk | input | 1 | Slave clock |
| csr_rst_n | input | 1 | Active-low async reset, slave domain |
| csr_addr | input | 21 | Byte address; only bits [2:0] decode |
| csr_read | input | 1 | Read strobe |
| csr_write | input | 1 | Write strobe |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Read data |
| csr_rvalid | output | 1 | Read data valid |
| csr_waitreq | output | 1 | Slave cannot accept a request |

## Verification
The capture path is tried with a single record whose fields are all ones, with short bursts of distinct counting patterns, and with an all-zero record. The all-ones record exposes reserved bits that leak into a byte. Distinct patterns expose a field placed at the wrong offset and records read out of order. A burst longer than the depth shows whether records offered while full are dropped and whether the full flag is exact. Pops while empty, control writes with bit 0 clear, and writes to read-only bytes, each followed by a read-back of the head record, show whether any of these moves the read pointer.

// File: rtl/tef_pkg.sv
package tef_pkg;

    localparam int VF_W  = 11;
    localparam int PF_W  = 3;
    localparam int LEN_W = 12;
    localparam int TAG_W = 10;
    localparam int TC_W  = 3;

    typedef struct packed {
        logic              vf_act;
        logic [PF_W-1:0]   pf;
        logic [VF_W-1:0]   vf;
        logic [LEN_W-1:0]  len;
        logic [TAG_W-1:0]  tag;
        logic [TC_W-1:0]   tc;
        logic              ro;
        logic              ns;
    } tev_rec_t;

    localparam int REC_W = $bits(tev_rec_t);

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_RESP = 2'd1,
        CS_POP  = 2'd2
    } csr_state_e;

    localparam logic [2:0] OFS_STAT  = 3'd0;
    localparam logic [2:0] OFS_CTRL  = 3'd1;
    localparam logic [2:0] OFS_VFLO  = 3'd2;
    localparam logic [2:0] OFS_FUNC  = 3'd3;
    localparam logic [2:0] OFS_LENLO = 3'd4;
    localparam logic [2:0] OFS_LENHI = 3'd5;
    localparam logic [2:0] OFS_TAGLO = 3'd6;
    localparam logic [2:0] OFS_MISC  = 3'd7;

endpackage

// File: rtl/tef_sync.sv
module tef_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tef_dcfifo.sv
module tef_dcfifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             wput,
    input  logic [WIDTH-1:0] wdata,
    output logic             wfull,
    output logic             wempty,
    output logic [PW-1:0]    wptr,
    input  logic             rclk,
    input  logic             rrst_n,
    input  logic             rpop,
    output logic [WIDTH-1:0] rdata,
    output logic             rfull,
    output logic             rempty
);
    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [WIDTH-1:0] mem [DEPTH];

    // write side
    logic [PW-1:0] wbin, wgray, wbin_nx, wgray_nx, wq2_rgray;
    logic          wtake;

    assign wtake    = wput && !wfull;
    assign wbin_nx  = wbin + PW'(wtake);
    assign wgray_nx = to_gray(wbin_nx);

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
            wfull <= 1'b0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
            wfull <= (wgray_nx == {~wq2_rgray[PW-1 -: 2], wq2_rgray[PW-3:0]});
        end
    end

    always_ff @(posedge wclk) begin
        if (wtake) mem[wbin[AW-1:0]] <= wdata;
    end

    assign wempty = (wgray == wq2_rgray);
    assign wptr   = wbin;

    // read side
    logic [PW-1:0] rbin, rgray, rbin_nx, rq2_wgray;

    assign rempty  = (rgray == rq2_wgray);
    assign rfull   = (rq2_wgray == {~rgray[PW-1 -: 2], rgray[PW-3:0]});
    assign rbin_nx = rbin + PW'(rpop && !rempty);

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= to_gray(rbin_nx);
        end
    end

    assign rdata = mem[rbin[AW-1:0]];

    tef_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(wq2_rgray));
    tef_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(rq2_wgray));
endmodule

// File: rtl/tef_csr_fsm.sv
module tef_csr_fsm
    import tef_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  tev_rec_t   head,
    input  logic       empty,
    input  logic       full,
    output logic [7:0] rdata,
    output logic       rvalid,
    output logic       waitreq,
    output logic       pop
);
    csr_state_e state, state_nx;
    logic       acc_rd, acc_wr, pop_go;
    logic [7:0] sel_byte;
    logic       unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[7:1];

    assign acc_rd = rd && (state == CS_IDLE);
    assign acc_wr = wr && !rd && (state == CS_IDLE);
    assign pop_go = acc_wr && (addr == OFS_CTRL) && wdata[0] && !empty;

    // byte window over the head record
    always_comb begin
        sel_byte = 8'h00;
        unique case (addr)
            OFS_STAT:  sel_byte = {6'b0, full, empty};
            OFS_CTRL:  sel_byte = 8'h00;
            OFS_VFLO:  sel_byte = head.vf[7:0];
            OFS_FUNC:  sel_byte = {head.vf_act, 1'b0, head.pf, head.vf[10:8]};
            OFS_LENLO: sel_byte = head.len[7:0];
            OFS_LENHI: sel_byte = {4'b0, head.len[11:8]};
            OFS_TAGLO: sel_byte = head.tag[7:0];
            OFS_MISC:  sel_byte = {head.tc, head.ro, head.ns, 1'b0, head.tag[9:8]};
            default:   sel_byte = 8'h00;
        endcase
        if (empty && (addr != OFS_STAT)) sel_byte = 8'h00;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CS_IDLE: begin
                if (acc_rd)      state_nx = CS_RESP;
                else if (pop_go) state_nx = CS_POP;
                else             state_nx = CS_IDLE;
            end
            CS_RESP: state_nx = CS_IDLE;
            CS_POP:  state_nx = CS_IDLE;
            default: state_nx = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= 8'h00;
        else if (acc_rd) rdata <= sel_byte;
    end

    assign rvalid  = (state == CS_RESP);
    assign waitreq = (state != CS_IDLE);
    assign pop     = pop_go;
endmodule

// File: rtl/cto_event_fifo.sv
module cto_event_fifo
    import tef_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 21,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic              core_clk,
    input  logic              core_rst_n,
    input  logic              evt_push,
    input  logic [VF_W-1:0]   evt_vf,
    input  logic [PF_W-1:0]   evt_pf,
    input  logic              evt_vf_active,
    input  logic [LEN_W-1:0]  evt_len,
    input  logic [TAG_W-1:0]  evt_tag,
    input  logic [TC_W-1:0]   evt_tc,
    input  logic              evt_ro,
    input  logic              evt_ns,
    output logic              alert,
    input  logic              csr_clk,
    input  logic              csr_rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_read,
    input  logic              csr_write,
    input  logic [7:0]        csr_wdata,
    output logic [7:0]        csr_rdata,
    output logic              csr_rvalid,
    output logic              csr_waitreq
);
    tev_rec_t          in_rec, head_rec;
    logic [REC_W-1:0]  head_bits;
    logic              wr_full, wr_empty, rd_full, rd_empty, do_pop;
    logic [PTR_W-1:0]  wr_ptr;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^csr_addr[ADDR_W-1:3];

    assign in_rec = '{vf_act: evt_vf_active, pf: evt_pf, vf: evt_vf, len: evt_len,
                      tag: evt_tag, tc: evt_tc, ro: evt_ro, ns: evt_ns};

    tef_dcfifo #(.DEPTH(DEPTH), .WIDTH(REC_W)) u_fifo (
        .wclk   (core_clk),
        .wrst_n (core_rst_n),
        .wput   (evt_push),
        .wdata  (in_rec),
        .wfull  (wr_full),
        .wempty (wr_empty),
        .wptr   (wr_ptr),
        .rclk   (csr_clk),
        .rrst_n (csr_rst_n),
        .rpop   (do_pop),
        .rdata  (head_bits),
        .rfull  (rd_full),
        .rempty (rd_empty)
    );

    assign head_rec = tev_rec_t'(head_bits);

    tef_csr_fsm u_csr (
        .clk     (csr_clk),
        .rst_n   (csr_rst_n),
        .addr    (csr_addr[2:0]),
        .rd      (csr_read),
        .wr      (csr_write),
        .wdata   (csr_wdata),
        .head    (head_rec),
        .empty   (rd_empty),
        .full    (rd_full),
        .rdata   (csr_rdata),
        .rvalid  (csr_rvalid),
        .waitreq (csr_waitreq),
        .pop     (do_pop)
    );

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) alert <= 1'b0;
        else             alert <= !wr_empty;
    end
endmodule

// File: rtl/tef_chk.sv
module tef_chk #(
    parameter int PW = 5
) (
    input logic          csr_clk,
    input logic          csr_rst_n,
    input logic          core_clk,
    input logic          core_rst_n,
    input logic          csr_read,
    input logic [2:0]    csr_ofs,
    input logic          csr_waitreq,
    input logic          csr_rvalid,
    input logic [7:0]    csr_rdata,
    input logic          rd_empty,
    input logic          evt_push,
    input logic          wr_full,
    input logic [PW-1:0] wr_ptr,
    input logic          alert
);
    // R6
    rvalid_follows_chk: assert property (@(posedge csr_clk) disable iff (!csr_rst_n)
        (csr_read && !csr_waitreq) |=> csr_rvalid);

    // R6
    rvalid_cause_chk: assert property (@(posedge csr_clk) disable iff (!csr_rst_n)
        csr_rvalid |-> $past(csr_read && !csr_waitreq));

    // R2
    status_byte_chk: assert property (@(posedge csr_clk) disable iff (!csr_rst_n)
        (csr_read && !csr_waitreq && csr_ofs == 3'd0)
        |=> (csr_rdata[7:2] == 6'b0 && csr_rdata[0] == $past(rd_empty)));

    // R7
    ctrl_zero_chk: assert property (@(posedge csr_clk) disable iff (!csr_rst_n)
        (csr_read && !csr_waitreq && csr_ofs == 3'd1) |=> csr_rdata == 8'h00);

    // R9
    empty_head_zero_chk: assert property (@(posedge csr_clk) disable iff (!csr_rst_n)
        (csr_read && !csr_waitreq && csr_ofs >= 3'd2 && rd_empty) |=> csr_rdata == 8'h00);

    // R5
    full_drop_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (evt_push && wr_full) |=> $stable(wr_ptr));

    // R1
    alert_rise_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (evt_push && !wr_full) |=> ##1 alert);
endmodule

bind cto_event_fifo tef_chk #(.PW(PTR_W)) u_chk (
    .csr_clk     (csr_clk),
    .csr_rst_n   (csr_rst_n),
    .core_clk    (core_clk),
    .core_rst_n  (core_rst_n),
    .csr_read    (csr_read),
    .csr_ofs     (csr_addr[2:0]),
    .csr_waitreq (csr_waitreq),
    .csr_rvalid  (csr_rvalid),
    .csr_rdata   (csr_rdata),
    .rd_empty    (rd_empty),
    .evt_push    (evt_push),
    .wr_full     (wr_full),
    .wr_ptr      (wr_ptr),
    .alert       (alert)
);

// File: tb/sim_cto_event_fifo.sv
`timescale 1ns/1ps
module sim_cto_event_fifo;
    import tef_pkg::*;

    localparam int DEPTH = 16;

    logic        core_clk = 0, csr_clk = 0;
    logic        core_rst_n = 0, csr_rst_n = 0;
    logic        evt_push = 0;
    tev_rec_t    drv = '0;
    logic        alert;
    logic [20:0] csr_addr = '0;
    logic        csr_read = 0, csr_write = 0;
    logic [7:0]  csr_wdata = '0;
    logic [7:0]  csr_rdata;
    logic        csr_rvalid, csr_waitreq;

    int total = 0, bad = 0;
    bit done = 0;
    tev_rec_t q[$];

    always #4 csr_clk = ~csr_clk;
    initial begin #3; forever #4 core_clk = ~core_clk; end

    cto_event_fifo #(.DEPTH(DEPTH)) u0 (
        .core_clk(core_clk), .core_rst_n(core_rst_n), .evt_push(evt_push),
        .evt_vf(drv.vf), .evt_pf(drv.pf), .evt_vf_active(drv.vf_act),
        .evt_len(drv.len), .evt_tag(drv.tag), .evt_tc(drv.tc),
        .evt_ro(drv.ro), .evt_ns(drv.ns), .alert(alert),
        .csr_clk(csr_clk), .csr_rst_n(csr_rst_n), .csr_addr(csr_addr),
        .csr_read(csr_read), .csr_write(csr_write), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid), .csr_waitreq(csr_waitreq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic tev_rec_t mk_rec(input int i);
        tev_rec_t r;
        r.vf     = 11'(i * 181 + 3);
        r.pf     = 3'(i);
        r.vf_act = i[0];
        r.len    = 12'(i * 293 + 7);
        r.tag    = 10'(i * 97 + 1);
        r.tc     = 3'(i + 2);
        r.ro     = i[1];
        r.ns     = i[2];
        return r;
    endfunction

    // R4 layout as stated in the requirement
    function automatic logic [7:0] exp_byte(input tev_rec_t r, input int ofs);
        case (ofs)
            2: return r.vf[7:0];
            3: return {r.vf_act, 1'b0, r.pf, r.vf[10:8]};
            4: return r.len[7:0];
            5: return {4'b0, r.len[11:8]};
            6: return r.tag[7:0];
            7: return {r.tc, r.ro, r.ns, 1'b0, r.tag[9:8]};
            default: return 8'h00;
        endcase
    endfunction

    // driver: offer one record, model keeps it if not full
    task automatic push_evt(input tev_rec_t r);
        @(negedge core_clk);
        drv = r;
        evt_push = 1;
        @(negedge core_clk);
        evt_push = 0;
        if (q.size() < DEPTH) q.push_back(r);
    endtask

    task automatic csr_rd(input logic [20:0] a, output logic [7:0] d);
        @(negedge csr_clk);
        while (csr_waitreq) @(negedge csr_clk);
        csr_addr = a;
        csr_read = 1;
        @(negedge csr_clk);
        csr_read = 0;
        chk("R6 rvalid", 16'(csr_rvalid), 16'h1);
        chk("R6 waitreq in resp", 16'(csr_waitreq), 16'h1);
        d = csr_rdata;
    endtask

    task automatic csr_wr(input logic [20:0] a, input logic [7:0] d);
        @(negedge csr_clk);
        while (csr_waitreq) @(negedge csr_clk);
        csr_addr = a;
        csr_wdata = d;
        csr_write = 1;
        @(negedge csr_clk);
        csr_write = 0;
    endtask

    task automatic settle();
        repeat (10) @(negedge csr_clk);
    endtask

    // monitor: compare head window with scoreboard front, then pop
    task automatic drain_one(input string req);
        logic [7:0] d;
        tev_rec_t   e;
        e = q.pop_front();
        for (int o = 2; o <= 7; o++) begin
            csr_rd(21'(o), d);
            chk($sformatf("%s R4 ofs%0d", req, o), 16'(d), 16'(exp_byte(e, o)));
        end
        csr_wr(21'd1, 8'h01);
    endtask

    initial begin
        repeat (200000) @(posedge csr_clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tev_rec_t a;
        repeat (4) @(negedge csr_clk);
        core_rst_n = 1;
        csr_rst_n = 1;
        settle();

        // reset state
        chk("R1 alert after reset", 16'(alert), 16'h0);
        chk("R6 waitreq after reset", 16'(csr_waitreq), 16'h0);
        csr_rd(21'd0, d); chk("R2 status reset", 16'(d), 16'h01);

        // empty window and pop while empty
        csr_rd(21'd6, d); chk("R9 empty head", 16'(d), 16'h00);
        csr_wr(21'd1, 8'h01);
        settle();
        csr_rd(21'd0, d); chk("R9 pop when empty", 16'(d), 16'h01);

        // single all-ones record
        a = '1;
        push_evt(a);
        settle();
        chk("R1 alert pending", 16'(alert), 16'h1);
        csr_rd(21'd0, d); chk("R2 status one", 16'(d), 16'h00);
        csr_rd(21'd7, d); chk("R4 misc byte ones", 16'(d), 16'(exp_byte(a, 7)));
        csr_rd(21'd3, d); chk("R4 func byte ones", 16'(d), 16'(exp_byte(a, 3)));
        csr_rd(21'd1, d); chk("R7 ctrl read", 16'(d), 16'h00);
        csr_wr(21'd2, 8'h00);
        csr_wr(21'd0, 8'hFF);
        csr_rd(21'd2, d); chk("R8 ro write", 16'(d), 16'(exp_byte(a, 2)));
        csr_rd(21'd0, d); chk("R8 status write", 16'(d), 16'h00);
        csr_wr(21'd1, 8'hFE);
        csr_rd(21'd0, d); chk("R3 zero bit no pop", 16'(d), 16'h00);
        csr_rd(21'h1FFFF8 | 21'd6, d); chk("R10 upper addr alias", 16'(d), 16'(exp_byte(a, 6)));
        drain_one("R3 R11 ones");
        settle();
        csr_rd(21'd0, d); chk("R3 pop empties", 16'(d), 16'h01);
        chk("R1 alert cleared", 16'(alert), 16'h0);

        // short burst of distinct records plus an all-zero one
        for (int i = 1; i <= 3; i++) push_evt(mk_rec(i));
        push_evt('0);
        settle();
        for (int i = 0; i < 4; i++) drain_one("R11 burst");
        settle();
        csr_rd(21'd0, d); chk("R11 burst drained", 16'(d), 16'h01);

        // overflow: DEPTH+3 offered, DEPTH kept
        for (int i = 10; i < 10 + DEPTH + 3; i++) push_evt(mk_rec(i));
        settle();
        csr_rd(21'd0, d); chk("R5 R2 status full", 16'(d), 16'h02);
        chk("R1 alert full", 16'(alert), 16'h1);
        for (int i = 0; i < DEPTH; i++) drain_one("R5 R11 full drain");
        settle();
        csr_rd(21'd0, d); chk("R5 extras dropped", 16'(d), 16'h01);
        csr_rd(21'd4, d); chk("R9 empty len", 16'(d), 16'h00);
        chk("R1 alert after drain", 16'(alert), 16'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule